// File: doc/BRIEF.md
# Video Memory Window Access Trap

This block watches physical memory requests and raises a trap the moment a request lands inside a 64 KB legacy video window. The window sits at a programmable 64 KB-aligned base. It is split into thirty-two 2 KB regions. A 32-bit exclusion mask holds one bit for each region, and an access to an excluded region passes without a trap.

The trap pulse is combinational, so it is raised in the same cycle the access is presented. A write buffer further down the pipe therefore cannot let later work run before the handler is told. On the pulse, the block latches the address and the access type and holds them until the handler acknowledges. Qualifying accesses that arrive while a trap is pending do not replace the latched record. They are tallied in a saturating drop counter.

Top module: `vid_window_trap`

## Requirements
- R1: An access traps only when address bits [ADDR_W-1:16] equal `win_base`; addresses outside the window never trap.
- R2: The region index is address bits [15:11]. Mask bit i set excludes region i (no trap); mask bit clear lets region i trap.
- R3: `trap_pulse` is asserted in the same cycle as the qualifying access, with no register in its path.
- R4: While `win_enable` is low, no access raises `trap_pulse`.
- R5: While `acc_valid` is low, no trap is raised, whatever the address.
- R6: On a trap pulse, the full access address and the write flag (1 = write) are latched. They stay unchanged while the trap is pending and unacknowledged.
- R7: `trap_pending` goes high in the cycle after a pulse and stays high until a cycle with `trap_ack` high.
- R8: A qualifying access that arrives while a trap is pending, with no acknowledge in that cycle, raises no pulse and increments `drop_count`, which saturates at its maximum. Excluded or out-of-window accesses do not count.
- R9: A qualifying access in the same cycle as `trap_ack` is taken as a new trap. It latches its own address and clears `drop_count` to 0.
- R10: After reset, `trap_pending`, `trap_addr`, `trap_write` and `drop_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| win_enable | input | 1 | Global trap enable |
| win_base | input | ADDR_W-16 | Upper address bits of the window base |
| excl_mask | input | 32 | Per-region exclusion bits, bit i for region i |
| trap_ack | input | 1 | Handler acknowledge, clears the pending trap |
| trap_pulse | output | 1 | Same-cycle trap request |
| trap_pending | output | 1 | A latched trap awaits acknowledge |
| trap_addr | output | ADDR_W | Latched trapping address |
| trap_write | output | 1 | Latched access type |
| drop_count | output | CNT_W | Qualifying accesses seen while pending (saturating) |

## Verification
Every region is hit at its first and last byte, for both reads and writes, under four masks: none, all bits set, an alternating pattern, and only that region's own bit. This separates wrong region-bit slicing from inverted mask polarity and from off-by-one region edges. Addresses in the 64 KB blocks on either side of the window, and a moved base, show whether the window compare covers every upper bit. Bursts of accesses during a pending trap, some excluded and some not, set saturation and the no-overwrite rule apart from counting the wrong accesses. An acknowledge that coincides with a new access tests the hand-over ordering.

// File: rtl/vid_window_trap.sv
module vid_window_trap #(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 16,
  parameter int REGION_BITS = 5,
  parameter int CNT_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       acc_write,
  input  logic                       win_enable,
  input  logic [ADDR_W-WIN_BITS-1:0] win_base,
  input  logic [(1<<REGION_BITS)-1:0] excl_mask,
  input  logic                       trap_ack,
  output logic                       trap_pulse,
  output logic                       trap_pending,
  output logic [ADDR_W-1:0]          trap_addr,
  output logic                       trap_write,
  output logic [CNT_W-1:0]           drop_count
);

  localparam int SUB_W = WIN_BITS - REGION_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [REGION_BITS-1:0] region;
  logic in_window, region_open, hit, busy;

  assign region      = acc_addr[WIN_BITS-1:SUB_W];
  assign in_window   = acc_addr[ADDR_W-1:WIN_BITS] == win_base;
  assign region_open = ~excl_mask[region];
  assign hit         = acc_valid & win_enable & in_window & region_open;
  assign busy        = trap_pending & ~trap_ack;
  assign trap_pulse  = hit & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_pending <= 1'b0;
      trap_addr    <= '0;
      trap_write   <= 1'b0;
      drop_count   <= '0;
    end else begin
      if (trap_pulse) begin
        trap_pending <= 1'b1;
        trap_addr    <= acc_addr;
        trap_write   <= acc_write;
        drop_count   <= '0;
      end else begin
        if (trap_ack) trap_pending <= 1'b0;
        if (hit && busy && drop_count != CNT_MAX) drop_count <= drop_count + 1'b1;
      end
    end
  end

  AST_NO_TRAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !win_enable |-> !trap_pulse); // R4
  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> acc_valid); // R5
  AST_PENDING_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |=> trap_pending); // R7
  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pending && !trap_ack) |=> ($stable(trap_addr) && $stable(trap_write))); // R6
  AST_NO_PULSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pending && !trap_ack) |-> !trap_pulse); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_MAX && !trap_pulse) |=> drop_count == CNT_MAX); // R8

endmodule

// File: tb/tb_vid_window_trap.sv
module tb_vid_window_trap;
  localparam int AW = 20;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, win_enable = 0, trap_ack = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [3:0] win_base = 4'hA;
  logic [31:0] excl_mask = '0;
  logic trap_pulse, trap_pending, trap_write;
  logic [AW-1:0] trap_addr;
  logic [CW-1:0] drop_count;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vid_window_trap #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .win_enable(win_enable), .win_base(win_base),
    .excl_mask(excl_mask), .trap_ack(trap_ack), .trap_pulse(trap_pulse),
    .trap_pending(trap_pending), .trap_addr(trap_addr), .trap_write(trap_write),
    .drop_count(drop_count));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [AW-1:0] a, input bit w, input bit ack);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_write = w; trap_ack = ack;
    #1;
  endtask

  function automatic bit expect_hit(input logic [AW-1:0] a, input logic [31:0] m);
    int rel;
    if (a[AW-1:16] != win_base) return 0;
    rel = int'(a) - (int'(win_base) << 16);
    return !m[rel / 2048];
  endfunction

  task automatic clear_trap();
    drive(0, '0, 0, 1);
    drive(0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] masks [4];
    logic [AW-1:0] a;
    bit e;
    repeat (3) @(negedge clk);
    #1;
    chk(trap_pending == 0 && drop_count == 0, "R10 pending/count", {trap_pending, drop_count}, 0);
    chk(trap_addr == 0 && trap_write == 0, "R10 record", trap_addr, 0);
    rst_n = 1;
    win_enable = 1;

    for (int r = 0; r < 32; r++) begin
      masks[0] = 32'h0; masks[1] = 32'hFFFF_FFFF; masks[2] = 32'h5555_AAAA; masks[3] = 32'h1 << r;
      for (int mi = 0; mi < 4; mi++)
        for (int off = 0; off < 2; off++)
          for (int w = 0; w < 2; w++) begin
            excl_mask = masks[mi];
            a = {win_base, 5'(r), (off != 0) ? 11'h7FF : 11'h000};
            e = expect_hit(a, excl_mask);
            drive(1, a, w[0], 0);
            chk(trap_pulse == e, "R2 R3 same-cycle pulse per region", trap_pulse, e);
            drive(0, '0, 0, 0);
            chk(trap_pending == e, "R7 pending after pulse", trap_pending, e);
            if (e) chk(trap_addr == a && trap_write == w[0], "R6 latched record", trap_addr, a);
            clear_trap();
            chk(trap_pending == 0, "R7 ack clears", trap_pending, 0);
          end
    end

    excl_mask = 0;
    foreach (masks[i]) ;
    for (int b = 0; b < 16; b++) begin
      a = {4'(b), 5'(b * 2), 11'h123};
      e = (b == 'hA);
      drive(1, a, 0, 0);
      chk(trap_pulse == e, "R1 window compare", trap_pulse, e);
      drive(0, '0, 0, 0);
      clear_trap();
    end
    win_base = 4'hC;
    drive(1, 20'hC4800, 1, 0);
    chk(trap_pulse == 1, "R1 moved base hits", trap_pulse, 1);
    drive(1, 20'hA4800, 1, 0);
    chk(trap_pulse == 0, "R1 old base misses", trap_pulse, 0);
    drive(0, '0, 0, 0);
    clear_trap();
    win_base = 4'hA;

    win_enable = 0;
    for (int r = 0; r < 32; r++) begin
      drive(1, {4'hA, 5'(r), 11'h40}, r[0], 0);
      chk(trap_pulse == 0, "R4 disabled no trap", trap_pulse, 0);
    end
    drive(0, '0, 0, 0);
    chk(trap_pending == 0, "R4 nothing latched", trap_pending, 0);
    win_enable = 1;

    drive(0, 20'hA0000, 0, 0);
    chk(trap_pulse == 0, "R5 invalid no trap", trap_pulse, 0);
    drive(0, '0, 0, 0);
    chk(trap_pending == 0, "R5 nothing latched", trap_pending, 0);

    excl_mask = 32'h0000_0002;
    drive(1, 20'hA0010, 1, 0);
    chk(trap_pulse == 1, "R8 first trap", trap_pulse, 1);
    drive(1, 20'hA0800, 0, 0);
    chk(trap_pulse == 0, "R8 excluded while busy", trap_pulse, 0);
    drive(1, 20'hB0000, 0, 0);
    drive(0, '0, 0, 0);
    chk(drop_count == 0, "R8 excluded/outside not counted", drop_count, 0);
    for (int k = 1; k <= 9; k++) begin
      drive(1, 20'hA1000 + AW'(k), 0, 0);
      chk(trap_pulse == 0, "R8 no pulse while pending", trap_pulse, 0);
      drive(0, '0, 0, 0);
      chk(drop_count == ((k > 7) ? 7 : k), "R8 saturating count", drop_count, (k > 7) ? 7 : k);
    end
    chk(trap_addr == 20'hA0010 && trap_write == 1, "R8 R6 record kept", trap_addr, 20'hA0010);

    drive(1, 20'hAF7FF, 0, 1);
    chk(trap_pulse == 1, "R9 ack with hit pulses", trap_pulse, 1);
    drive(0, '0, 0, 0);
    chk(trap_pending == 1 && drop_count == 0, "R9 new trap, count cleared", drop_count, 0);
    chk(trap_addr == 20'hAF7FF && trap_write == 0, "R9 new record", trap_addr, 20'hAF7FF);
    clear_trap();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule